// File: doc/BRIEF.md
# Dual Path-Estimate FIR Filter

This block takes a stream of reference microphone samples and, for every sample, produces two model signals for a feed-forward noise canceller. The first is the noise as it is predicted to arrive at the ear. The second is the reference filtered through the model of the loudspeaker-to-ear path, which the adaptive stage uses for its coefficient update. Both are fixed 64-tap FIR filters over the same input, so the block keeps a single history of recent samples that both filters read.

A pulse on `start_i` stores the new sample and begins one pass. A single multiplier-accumulator then does 64 products for the primary-path model, followed by 64 products for the secondary-path model. Both rounded results are presented together with a one-cycle valid strobe. The coefficient sets come from an offline training step. They are written through a small write port while the block is idle and then stay constant during cancellation.

Top module: `dual_path_fir`

## Requirements
- R1: While reset is active and after it is released, `valid_o` is 0, `d_o` and `xf_o` are 0, and every history entry reads as zero.
- R2: `d_o` equals the rounded and saturated value of the sum over m = 0..63 of primary coefficient m times x(n−m). Here x(n) is the sample taken with the latest accepted start.
- R3: The history advances by exactly one entry on each accepted start. Tap index 0 always multiplies the newest sample, and tap index 63 multiplies the sample taken 63 starts earlier.
- R4: `xf_o` equals the rounded and saturated value of the same sum, using the secondary coefficients over the same history.
- R5: A coefficient write with `cw_en_i` = 1 stores `cw_data_i` at tap `cw_tap_i` (0..63). It goes to the primary set when `cw_sel_i` = 0 and to the secondary set when `cw_sel_i` = 1. The write is accepted only while idle, and a write during a pass has no effect.
- R6: `valid_o` rises exactly 130 rising clock edges after the edge that accepts a start, counting that edge as the first. It stays high for one cycle. Both outputs are updated at that edge.
- R7: `d_o` and `xf_o` hold their values in every cycle in which `valid_o` is low.
- R8: A start pulse that arrives while a pass is in progress is ignored. It neither enters the history nor begins a new pass.
- R9: Rounding adds 2^14 to the 40-bit accumulator and shifts it arithmetically right by 15 (Q15 coefficients). The result saturates to the range [−32768, 32767].
- R10: Reset does not clear the coefficient sets. Coefficients written before a reset still apply after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Take `x_i` and begin a pass (accepted while idle) |
| x_i | input | 16 | Reference sample, signed |
| cw_en_i | input | 1 | Coefficient write enable |
| cw_sel_i | input | 1 | Coefficient set: 0 primary, 1 secondary |
| cw_tap_i | input | 6 | Tap index of the write |
| cw_data_i | input | 16 | Coefficient value, signed Q15 |
| valid_o | output | 1 | One-cycle strobe: both outputs are new |
| d_o | output | 16 | Primary-path model output, signed |
| xf_o | output | 16 | Secondary-path filtered reference, signed |

## Verification
The bench builds the block with its default values: 64 taps, 16-bit samples and coefficients, and a 40-bit accumulator. With 64 taps, a run of 64 full-scale samples drives both filters into saturation in both directions, and the accumulator still does not overflow. The 6-bit tap index, with a 7-bit pass counter that splits it into two halves, is exercised across its wrap, because the history is filled past 64 samples with varied data and checked against a reference model. A pass of 130 cycles also leaves room to inject a stray start pulse and a coefficient write in the middle of a pass.

// File: rtl/dpf_pkg.sv
package dpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } dpf_state_e;
endpackage

// File: rtl/dpf_hist_ring.sv
module dpf_hist_ring #(
  parameter int DEPTH = 64,
  parameter int DW    = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic signed [DW-1:0] data_i,
  input  logic        [IW-1:0] rd_off_i,
  output logic signed [DW-1:0] rd_data_o
);
  logic signed [DW-1:0] mem [DEPTH];
  logic [IW-1:0] head_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_i) begin
      mem[head_q + IW'(1)] <= data_i;
      head_q <= head_q + IW'(1);
    end
  end

  // depth is a power of two: offset wraps naturally
  assign rd_data_o = mem[head_q - rd_off_i];

  p_head_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> head_q == $past(head_q) + IW'(1));
  p_head_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> head_q == $past(head_q));
endmodule

// File: rtl/dpf_coef_bank.sv
module dpf_coef_bank #(
  parameter int TAPS = 64,
  parameter int CW   = 16,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 idle_i,
  input  logic                 we_i,
  input  logic                 sel_i,
  input  logic        [IW-1:0] tap_i,
  input  logic signed [CW-1:0] data_i,
  input  logic                 rd_sel_i,
  input  logic        [IW-1:0] rd_tap_i,
  output logic signed [CW-1:0] coef_o
);
  logic signed [CW-1:0] rd_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic signed [CW-1:0] mem [TAPS];
    // no reset: trained values survive it
    always_ff @(posedge clk_i) begin
      if (we_i && sel_i == 1'(b)) mem[tap_i] <= data_i;
    end
    assign rd_q[b] = mem[rd_tap_i];
  end

  assign coef_o = rd_q[rd_sel_i];

  p_wr_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> idle_i);
endmodule

// File: rtl/dpf_mac.sv
module dpf_mac #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 40
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [CW-1:0] b_i,
  output logic signed [AW-1:0] sum_o,
  output logic signed [AW-1:0] acc_o
);
  localparam int PW = DW + CW;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = a_i * b_i;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};
  assign sum_o    = (clr_i ? '0 : acc_o) + prod_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= sum_o;
  end
endmodule

// File: rtl/dual_path_fir.sv
module dual_path_fir #(
  parameter int TAPS = 64,
  parameter int DW   = 16,
  parameter int CW   = 16,
  parameter int AW   = 40,
  parameter int FRAC = 15,
  localparam int IW  = $clog2(TAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic signed [DW-1:0] x_i,
  input  logic                 cw_en_i,
  input  logic                 cw_sel_i,
  input  logic        [IW-1:0] cw_tap_i,
  input  logic signed [CW-1:0] cw_data_i,
  output logic                 valid_o,
  output logic signed [DW-1:0] d_o,
  output logic signed [DW-1:0] xf_o
);
  import dpf_pkg::*;

  localparam logic [IW:0] K_MID  = (IW+1)'(TAPS - 1);
  localparam logic [IW:0] K_LAST = (IW+1)'(2*TAPS - 1);
  localparam logic signed [AW:0] MAXV = (AW+1)'((1 <<< (DW-1)) - 1);
  localparam logic signed [AW:0] MINV = ~MAXV;
  localparam logic signed [AW:0] HALF = (AW+1)'(1) <<< (FRAC-1);

  dpf_state_e           state_q;
  logic [IW:0]          k_q;
  logic signed [AW-1:0] d_acc_q, sum, acc;
  logic signed [DW-1:0] h_data;
  logic signed [CW-1:0] c_data;
  logic                 idle, start_ok, run;

  assign idle     = (state_q == ST_IDLE);
  assign run      = (state_q == ST_RUN);
  assign start_ok = start_i && idle;

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [AW-1:0] a);
    logic signed [AW:0] t;
    t = {a[AW-1], a} + HALF;
    t = t >>> FRAC;
    if (t > MAXV)      return MAXV[DW-1:0];
    else if (t < MINV) return MINV[DW-1:0];
    else               return t[DW-1:0];
  endfunction

  dpf_hist_ring #(.DEPTH(TAPS), .DW(DW)) u_hist (
    .clk_i, .rst_ni,
    .wr_i     (start_ok),
    .data_i   (x_i),
    .rd_off_i (k_q[IW-1:0]),
    .rd_data_o(h_data)
  );

  dpf_coef_bank #(.TAPS(TAPS), .CW(CW)) u_coef (
    .clk_i, .rst_ni,
    .idle_i  (idle),
    .we_i    (cw_en_i && idle),
    .sel_i   (cw_sel_i),
    .tap_i   (cw_tap_i),
    .data_i  (cw_data_i),
    .rd_sel_i(k_q[IW]),
    .rd_tap_i(k_q[IW-1:0]),
    .coef_o  (c_data)
  );

  dpf_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
    .clk_i, .rst_ni,
    .en_i (run),
    .clr_i(k_q[IW-1:0] == '0),
    .a_i  (h_data),
    .b_i  (c_data),
    .sum_o(sum),
    .acc_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      k_q     <= '0;
      d_acc_q <= '0;
      valid_o <= 1'b0;
      d_o     <= '0;
      xf_o    <= '0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RUN;
          k_q     <= '0;
        end
        ST_RUN: begin
          k_q <= k_q + 1'b1;
          if (k_q == K_MID)  d_acc_q <= sum;   // primary half done
          if (k_q == K_LAST) state_q <= ST_FIN;
        end
        ST_FIN: begin
          d_o     <= rnd_sat(d_acc_q);
          xf_o    <= rnd_sat(acc);
          valid_o <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker-side latency counter
  logic [IW+1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          lat_q <= '0;
    else if (start_ok)    lat_q <= (IW+2)'(1);
    else if (valid_o)     lat_q <= '0;
    else if (lat_q != '0) lat_q <= lat_q + 1'b1;
  end

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> lat_q == (IW+2)'(2*TAPS + 2));
  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(d_o) && $stable(xf_o));
endmodule

// File: tb/tb_dual_path_fir.sv
module tb_dual_path_fir;
  localparam int TAPS = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n, start, cw_en, cw_sel, valid;
  logic signed [15:0] x, cw_data, d, xf;
  logic        [5:0]  cw_tap;

  dual_path_fir dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .x_i(x),
    .cw_en_i(cw_en), .cw_sel_i(cw_sel), .cw_tap_i(cw_tap), .cw_data_i(cw_data),
    .valid_o(valid), .d_o(d), .xf_o(xf)
  );

  int n_chk = 0, n_bad = 0;
  int cp[TAPS], cs[TAPS], mh[TAPS];
  int seed = 12345;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1_500_000ns;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    summary();
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd(int lim);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fff_ffff) % lim;
  endfunction

  // R9: add 2^14, arithmetic shift by 15, clamp
  function automatic int rs(longint a);
    longint t = (a + 64'sd16384) >>> 15;
    if (t > 32767)  return 32767;
    if (t < -32768) return -32768;
    return int'(t);
  endfunction

  function automatic int model(bit sec);
    longint a = 0;
    for (int m = 0; m < TAPS; m++) a += longint'(sec ? cs[m] : cp[m]) * longint'(mh[m]);
    return rs(a);
  endfunction

  task automatic wcoef(bit sel, int tap, int val);
    @(negedge clk);
    cw_en = 1'b1; cw_sel = sel; cw_tap = 6'(tap); cw_data = 16'(val);
    @(negedge clk);
    cw_en = 1'b0;
    if (sel) cs[tap] = val; else cp[tap] = val;
  endtask

  task automatic clear_hist();
    for (int m = 0; m < TAPS; m++) mh[m] = 0;
  endtask

  task automatic push(int xv, string req);
    int n = 0;
    int hd, hx;
    for (int m = TAPS-1; m > 0; m--) mh[m] = mh[m-1];
    mh[0] = xv;
    @(negedge clk);
    start = 1'b1; x = 16'(xv);
    @(negedge clk);
    start = 1'b0;
    while (!valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R6 latency", n, 129);
    check({req, " d"}, int'(d), model(0));
    check({req, " xf"}, int'(xf), model(1));
    hd = int'(d); hx = int'(xf);
    @(negedge clk);
    check("R6 pulse", int'(valid), 0);
    check("R7 hold d", int'(d), hd);
    check("R7 hold xf", int'(xf), hx);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(valid), 0);
    check("R1 d", int'(d), 0);
    check("R1 xf", int'(xf), 0);
  endtask

  task automatic t_impulse();
    for (int m = 0; m < TAPS; m++) begin
      wcoef(0, m, (m + 1) * 100);
      wcoef(1, m, -(m * 37) + 500);
    end
    push(20000, "R2 R4 impulse");
    for (int i = 1; i < 70; i++) push(0, "R3 impulse walk");
  endtask

  task automatic t_random();
    for (int m = 0; m < TAPS; m++) begin
      wcoef(0, m, rnd(8000) - 4000);
      wcoef(1, m, rnd(8000) - 4000);
    end
    for (int i = 0; i < 40; i++) push(rnd(65536) - 32768, "R2 R3 R4 random");
  endtask

  task automatic t_round();
    for (int m = 0; m < TAPS; m++) begin
      wcoef(0, m, (m == 0) ? 1 : 0);
      wcoef(1, m, (m == 0) ? -1 : 0);
    end
    push(16384, "R9 round up");
    check("R9 d=1", int'(d), 1);
    push(16383, "R9 round down");
    check("R9 d=0", int'(d), 0);
    push(-16385, "R9 neg");
    check("R9 d=-1", int'(d), -1);
  endtask

  task automatic t_saturate();
    for (int m = 0; m < TAPS; m++) begin
      wcoef(0, m, 32767);
      wcoef(1, m, -32768);
    end
    for (int i = 0; i < TAPS; i++) push(32767, "R9 saturate");
    check("R9 pos sat", int'(d), 32767);
    check("R9 neg sat", int'(xf), -32768);
  endtask

  task automatic t_busy();
    int n = 0;
    for (int m = 0; m < TAPS; m++) begin
      wcoef(0, m, rnd(8000) - 4000);
      wcoef(1, m, rnd(8000) - 4000);
    end
    for (int i = 0; i < 5; i++) push(rnd(20000) - 10000, "R3 busy prefill");
    for (int m = TAPS-1; m > 0; m--) mh[m] = mh[m-1];
    mh[0] = 1234;
    @(negedge clk);
    start = 1'b1; x = 16'(1234);
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    // R8 stray start and R5 stray write mid-pass
    start = 1'b1; x = 16'(7777);
    cw_en = 1'b1; cw_sel = 1'b0; cw_tap = 6'd0; cw_data = 16'(29999);
    @(negedge clk);
    start = 1'b0; cw_en = 1'b0;
    while (!valid && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R8 R5 d", int'(d), model(0));
    check("R8 xf", int'(xf), model(1));
    push(-321, "R8 R5 after busy");
  endtask

  task automatic t_reset_keep();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    clear_hist();
    push(1000, "R1 R10 after reset");
    check("R10 d", int'(d), rs(longint'(cp[0]) * 1000));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; x = '0;
    cw_en = 1'b0; cw_sel = 1'b0; cw_tap = '0; cw_data = '0;
    clear_hist();
    for (int m = 0; m < TAPS; m++) begin cp[m] = 0; cs[m] = 0; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_impulse();
    t_random();
    t_round();
    t_saturate();
    t_busy();
    t_reset_keep();
    summary();
    $finish;
  end
endmodule